// File: doc/BRIEF.md
# Bus-Matching Byte Steering Unit

This unit sits between a storage path that moves 18-bit words, each made of two 9-bit bytes, and a port that carries one 9-bit byte at a time. In the byte-to-word direction it collects bytes into words. A lone first byte waits in a holding register, and a valid flag shows that the register is occupied. A flush request sends a held byte out early as a zero-padded word. In the word-to-byte direction it presents the head word one byte at a time. It signals a pop once both bytes have been taken. A single control input picks whether the low or the high byte travels first on the byte port.

Two units can share one byte port to convert between 36 bits and 9 bits. One unit runs as master and counts every byte strobe on the shared port in a group of four. It drives a select line to its partner during the first two slots of each group and keeps the last two slots for itself. The partner runs as slave and takes a byte only while that select line is high. In stand-alone mode the unit takes every byte. Stand-alone mode covers both the 18-to-9 case and the 36-to-18 case.

Top module: `byte_steer`

## Requirements
- R1: After reset, the hold flag `odd_valid_o` is 0, `word_push_o` is 0, the read half pointer selects the first byte, and the master slot counter is 0, so in master mode `slave_sel_o` is 1.
- R2: With `byte_order_i`=0, the first accepted byte of a pair lands in bits [8:0] and the second in bits [17:9]. The completed word appears on `word_data_o` with `word_push_o` high for one cycle after the clock edge that accepts the second byte.
- R3: With `byte_order_i`=1, the first accepted byte lands in bits [17:9] and the second in bits [8:0].
- R4: An accepted byte that arrives while nothing is held (and with no flush) sets `odd_valid_o` at the next edge. The accepted byte that completes the word clears it. `word_push_o` is never high while `odd_valid_o` is high.
- R5: `flush_i` while a byte is held and no byte is written pushes that byte as a word. The missing half is zero: bits [17:9] for order 0, bits [8:0] for order 1. The flush also clears `odd_valid_o`. `flush_i` with nothing held and no write has no effect.
- R6: The write is applied before the flush. When `flush_i` comes together with an accepted byte that completes a word, a single normal word is pushed. When it comes with an accepted lone byte, that byte is pushed at once, padded, and `odd_valid_o` stays 0.
- R7: `byte_rd_data_o` shows the byte of `word_rd_data_i` that the read half pointer selects: low then high for order 0, high then low for order 1. An accepted `byte_rd_i` advances the pointer. `word_pop_o` is high combinationally on the accepted read of the second byte, and after that read the pointer returns to the first byte.
- R8: Master mode (`mode_i`=2'b01): each cycle with `byte_wr_i` or `byte_rd_i` high advances the slot counter by one, modulo 4. `slave_sel_o` is high in slots 0 and 1. `byte_accept_o` is high only in slots 2 and 3.
- R9: Slave mode (`mode_i`=2'b10): `byte_accept_o` follows `slave_sel_i`. A strobe with `slave_sel_i` low changes no state: no push, no pop, no change to `odd_valid_o` or to the read pointer.
- R10: Stand-alone mode (`mode_i`=2'b00 or 2'b11): every strobe is accepted and `slave_sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00/11 stand-alone, 01 master, 10 slave |
| byte_order_i | input | 1 | 0: low byte first, 1: high byte first |
| slave_sel_i | input | 1 | Select line from a master (used in slave mode) |
| byte_wr_i | input | 1 | Byte write strobe on the byte port |
| byte_wr_data_i | input | 9 | Byte written |
| flush_i | input | 1 | Push a held byte out, padded |
| byte_rd_i | input | 1 | Byte read strobe on the byte port |
| word_rd_data_i | input | 18 | Head word of the outgoing path |
| byte_rd_data_o | output | 9 | Byte presented for reading |
| byte_accept_o | output | 1 | This unit takes the current byte slot |
| slave_sel_o | output | 1 | Select line to the slave (master mode) |
| word_push_o | output | 1 | Assembled word valid, one cycle |
| word_data_o | output | 18 | Assembled word |
| word_pop_o | output | 1 | Head word fully consumed |
| odd_valid_o | output | 1 | Holding register occupied |

## Verification
Assertions run on every cycle and check the following. The hold flag and a push are never high together. A held lone byte raises the flag. The slot counter steps by one on each strobe and stays put without one. In master mode accept and select are mutually exclusive. The read pointer rewinds after a pop. A slave that is not selected never accepts, pushes or pops. The byte placement for each order, the zero padding on flush, the ordering when a flush and a write coincide, and the full four-slot exchange can only be shown by the bench. It compares the ports against a model under directed and random traffic in each mode.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    MODE_SOLO     = 2'b00,
    MODE_MASTER   = 2'b01,
    MODE_SLAVE    = 2'b10,
    MODE_SOLO_ALT = 2'b11
  } mode_e;

  function automatic logic is_solo(mode_e m);
    return (m == MODE_SOLO) || (m == MODE_SOLO_ALT);
  endfunction
endpackage

// File: rtl/bm_slot_ctrl.sv
module bm_slot_ctrl #(
  parameter int GROUP = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bm_pkg::mode_e mode_i,
  input  logic          strobe_i,
  input  logic          slave_sel_i,
  output logic          accept_o,
  output logic          slave_sel_o
);
  localparam int CW   = (GROUP > 2) ? $clog2(GROUP) : 1;
  localparam int HALF = GROUP / 2;
  localparam logic [CW-1:0] LAST  = CW'(GROUP - 1);
  localparam logic [CW-1:0] SPLIT = CW'(HALF);

  logic [CW-1:0] cnt_q;
  logic          master;

  assign master = (mode_i == bm_pkg::MODE_MASTER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (master && strobe_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  // first half of each group belongs to the partner
  assign slave_sel_o = master && (cnt_q < SPLIT);

  always_comb begin
    unique case (mode_i)
      bm_pkg::MODE_MASTER: accept_o = (cnt_q >= SPLIT);
      bm_pkg::MODE_SLAVE:  accept_o = slave_sel_i;
      default:             accept_o = 1'b1;
    endcase
  end

  p_count_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master && strobe_i) |=> (cnt_q == (($past(cnt_q) == LAST) ? '0 : $past(cnt_q) + 1'b1)));

  p_count_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(master && strobe_i) |=> $stable(cnt_q));

  p_master_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master |-> (accept_o != slave_sel_o));
endmodule

// File: rtl/bm_pack.sv
module bm_pack #(
  parameter int BYTE_W = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                order_i,
  input  logic                wr_i,
  input  logic [BYTE_W-1:0]   data_i,
  input  logic                flush_i,
  output logic                push_o,
  output logic [2*BYTE_W-1:0] word_o,
  output logic                odd_valid_o
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] odd_q;
  logic              odd_valid_q;
  logic              push_q;
  logic [WORD_W-1:0] word_q;
  logic              complete, lone_flush;
  logic [BYTE_W-1:0] lone_b;
  logic [WORD_W-1:0] full_w, pad_w;

  assign complete   = wr_i && odd_valid_q;
  // write goes in first; a flush then sends out whatever single byte is left
  assign lone_flush = flush_i && (wr_i ^ odd_valid_q);
  assign lone_b     = wr_i ? data_i : odd_q;
  assign full_w     = order_i ? {odd_q, data_i} : {data_i, odd_q};
  assign pad_w      = order_i ? {lone_b, {BYTE_W{1'b0}}} : {{BYTE_W{1'b0}}, lone_b};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_q       <= '0;
      odd_valid_q <= 1'b0;
      push_q      <= 1'b0;
      word_q      <= '0;
    end else begin
      push_q <= complete || lone_flush;
      if (complete) begin
        word_q      <= full_w;
        odd_valid_q <= 1'b0;
      end else if (lone_flush) begin
        word_q      <= pad_w;
        odd_valid_q <= 1'b0;
      end else if (wr_i) begin
        odd_q       <= data_i;
        odd_valid_q <= 1'b1;
      end
    end
  end

  assign push_o      = push_q;
  assign word_o      = word_q;
  assign odd_valid_o = odd_valid_q;

  p_push_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !odd_valid_o);

  p_lone_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !odd_valid_o && !flush_i) |=> (odd_valid_o && !push_o));

  p_flush_drain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !wr_i && odd_valid_o) |=> (push_o && !odd_valid_o));

  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !(flush_i && odd_valid_o)) |=> !push_o);
endmodule

// File: rtl/bm_unpack.sv
module bm_unpack #(
  parameter int BYTE_W = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                order_i,
  input  logic                rd_i,
  input  logic [2*BYTE_W-1:0] word_i,
  output logic [BYTE_W-1:0]   byte_o,
  output logic                pop_o
);
  logic half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else if (rd_i) half_q <= ~half_q;
  end

  assign byte_o = (half_q ^ order_i) ? word_i[2*BYTE_W-1:BYTE_W] : word_i[BYTE_W-1:0];
  assign pop_o  = rd_i && half_q;

  p_pop_rewind_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> !half_q);

  p_first_advance_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !pop_o) |=> half_q);
endmodule

// File: rtl/byte_steer.sv
module byte_steer #(
  parameter int BYTE_W = 9,
  parameter int GROUP  = 4,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              byte_order_i,
  input  logic              slave_sel_i,
  input  logic              byte_wr_i,
  input  logic [BYTE_W-1:0] byte_wr_data_i,
  input  logic              flush_i,
  input  logic              byte_rd_i,
  input  logic [WORD_W-1:0] word_rd_data_i,
  output logic [BYTE_W-1:0] byte_rd_data_o,
  output logic              byte_accept_o,
  output logic              slave_sel_o,
  output logic              word_push_o,
  output logic [WORD_W-1:0] word_data_o,
  output logic              word_pop_o,
  output logic              odd_valid_o
);
  bm_pkg::mode_e mode;
  logic          accept;

  assign mode = bm_pkg::mode_e'(mode_i);

  bm_slot_ctrl #(.GROUP(GROUP)) u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .strobe_i    (byte_wr_i || byte_rd_i),
    .slave_sel_i (slave_sel_i),
    .accept_o    (accept),
    .slave_sel_o (slave_sel_o)
  );

  bm_pack #(.BYTE_W(BYTE_W)) u_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .order_i     (byte_order_i),
    .wr_i        (byte_wr_i && accept),
    .data_i      (byte_wr_data_i),
    .flush_i     (flush_i),
    .push_o      (word_push_o),
    .word_o      (word_data_o),
    .odd_valid_o (odd_valid_o)
  );

  bm_unpack #(.BYTE_W(BYTE_W)) u_unpack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .order_i (byte_order_i),
    .rd_i    (byte_rd_i && accept),
    .word_i  (word_rd_data_i),
    .byte_o  (byte_rd_data_o),
    .pop_o   (word_pop_o)
  );

  assign byte_accept_o = accept;

  p_slave_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == bm_pkg::MODE_SLAVE && !slave_sel_i) |-> (!byte_accept_o && !word_pop_o));

  p_slave_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == bm_pkg::MODE_SLAVE && !slave_sel_i && !flush_i) |=> ($stable(odd_valid_o) && !word_push_o));

  p_solo_take_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bm_pkg::is_solo(mode) |-> (byte_accept_o && !slave_sel_o));
endmodule

// File: tb/byte_steer_test.sv
module byte_steer_test;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 9;
  localparam int WW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          order = 1'b0;
  logic          sel_in = 1'b0;
  logic          wr = 1'b0;
  logic [BW-1:0] wdata = '0;
  logic          flush = 1'b0;
  logic          rd = 1'b0;
  logic [WW-1:0] rword = '0;
  logic [BW-1:0] rbyte;
  logic          accept, sel_out, push, pop, ov;
  logic [WW-1:0] wword;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // model state
  logic          m_ov = 1'b0;
  logic [BW-1:0] m_odd = '0;
  logic          m_half = 1'b0;
  int            m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_steer uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .byte_order_i(order),
    .slave_sel_i(sel_in), .byte_wr_i(wr), .byte_wr_data_i(wdata),
    .flush_i(flush), .byte_rd_i(rd), .word_rd_data_i(rword),
    .byte_rd_data_o(rbyte), .byte_accept_o(accept), .slave_sel_o(sel_out),
    .word_push_o(push), .word_data_o(wword), .word_pop_o(pop),
    .odd_valid_o(ov)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic f_accept(logic [1:0] md, int cnt, logic s);
    if (md == 2'b01) return cnt >= 2;
    if (md == 2'b10) return s;
    return 1'b1;
  endfunction

  function automatic logic [WW-1:0] f_join(logic o, logic [BW-1:0] first, logic [BW-1:0] second);
    return o ? {first, second} : {second, first};
  endfunction

  function automatic logic [WW-1:0] f_pad(logic o, logic [BW-1:0] b);
    return o ? {b, {BW{1'b0}}} : {{BW{1'b0}}, b};
  endfunction

  function automatic logic [BW-1:0] f_pick(logic o, logic h, logic [WW-1:0] w);
    return (o ^ h) ? w[WW-1:BW] : w[BW-1:0];
  endfunction

  function automatic string f_mode_tag(logic [1:0] md);
    if (md == 2'b01) return "R8";
    if (md == 2'b10) return "R9";
    return "R10";
  endfunction

  // one cycle: drive at negedge, check combinational, clock, check registered
  task automatic step(input logic w, input logic [BW-1:0] d, input logic f,
                      input logic r, input logic s);
    logic a, e_push;
    logic [WW-1:0] e_word;
    string wtag;
    wr = w; wdata = d; flush = f; rd = r; sel_in = s;
    rword = WW'($urandom);
    #1;
    a = f_accept(mode, m_cnt, s);
    chk(accept == a, f_mode_tag(mode), 32'(accept), 32'(a));
    chk(sel_out == (mode == 2'b01 && m_cnt < 2), "R8", 32'(sel_out), 32'(mode == 2'b01 && m_cnt < 2));
    chk(rbyte == f_pick(order, m_half, rword), "R7", 32'(rbyte), 32'(f_pick(order, m_half, rword)));
    chk(pop == (r && a && m_half), "R7", 32'(pop), 32'(r && a && m_half));
    e_push = 1'b0; e_word = '0; wtag = order ? "R3" : "R2";
    if (w && a && m_ov) begin
      e_push = 1'b1; e_word = f_join(order, m_odd, d); m_ov = 1'b0;
      if (f) wtag = "R6";
    end else if (f && ((w && a) ^ m_ov)) begin
      e_push = 1'b1; e_word = f_pad(order, (w && a) ? d : m_odd); m_ov = 1'b0;
      wtag = (w && a) ? "R6" : "R5";
    end else if (w && a) begin
      m_odd = d; m_ov = 1'b1;
    end
    if (r && a) m_half = ~m_half;
    if (mode == 2'b01 && (w || r)) m_cnt = (m_cnt + 1) % 4;
    @(posedge clk);
    @(negedge clk);
    chk(push == e_push, (f ? "R5" : "R4"), 32'(push), 32'(e_push));
    if (e_push) chk(wword == e_word, wtag, 32'(wword), 32'(e_word));
    chk(ov == m_ov, "R4", 32'(ov), 32'(m_ov));
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int seed;
    seed = $urandom(32'd20240611);
    mode = 2'b01;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(ov == 1'b0, "R1", 32'(ov), 0);
    chk(push == 1'b0, "R1", 32'(push), 0);
    chk(sel_out == 1'b1, "R1", 32'(sel_out), 1);
    rword = 18'h2A5C3;
    #1;
    chk(rbyte == rword[8:0], "R1", 32'(rbyte), 32'(rword[8:0]));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3 / R4 stand-alone assembly
    mode = 2'b00; order = 1'b0;
    step(1, 9'h1A1, 0, 0, 0);
    step(0, 9'h000, 0, 0, 0);
    step(1, 9'h0B2, 0, 0, 0);
    order = 1'b1;
    step(1, 9'h155, 0, 0, 0);
    step(1, 9'h0AA, 0, 0, 0);
    // R5 flush with held byte, both orders, and flush with nothing held
    step(1, 9'h1FF, 0, 0, 0);
    step(0, 9'h000, 1, 0, 0);
    order = 1'b0;
    step(1, 9'h123, 0, 0, 0);
    step(0, 9'h000, 1, 0, 0);
    step(0, 9'h000, 1, 0, 0);
    // R6 flush together with write
    step(1, 9'h045, 1, 0, 0);
    step(1, 9'h067, 0, 0, 0);
    step(1, 9'h189, 1, 0, 0);
    // R7 reads in both orders
    step(0, 0, 0, 1, 0); step(0, 0, 0, 1, 0);
    order = 1'b1;
    step(0, 0, 0, 1, 0); step(0, 0, 0, 1, 0);
    // R10 alternate stand-alone code
    mode = 2'b11;
    step(1, 9'h011, 0, 1, 0); step(1, 9'h022, 0, 1, 0);
    // R8 master through two groups
    mode = 2'b01; order = 1'b0;
    for (int i = 0; i < 8; i++) step(1, 9'(i + 9'h30), 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0);
    // R9 slave ignores strobes while unselected
    mode = 2'b10;
    step(1, 9'h0F0, 0, 1, 0);
    step(1, 9'h0F1, 0, 1, 1);
    step(1, 9'h0F2, 0, 1, 0);
    step(1, 9'h0F3, 0, 0, 1);

    // random traffic in every mode
    for (int p = 0; p < 4; p++) begin
      mode = 2'(p);
      for (int i = 0; i < 1500; i++) begin
        if (($urandom % 64) == 0) order = 1'($urandom);
        step(1'(($urandom % 3) != 0), 9'($urandom), 1'(($urandom % 8) == 0),
             1'(($urandom % 2) == 0), 1'($urandom));
      end
    end

    wr = 0; rd = 0; flush = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule